// File: doc/BRIEF.md
# DDR2 Main Mode Register Load Unit

This block is the device-side model of a DDR2 main mode register and of the load-mode command that writes it. Each clock it samples a decoded command strobe, along with a flag that marks the command as a load-mode command, the bank address, the row address bits, a status that says all banks are precharged and a flag that says a burst is running. A load-mode command aimed at bank address 00 writes the register. A load aimed at 01, 10 or 11 only raises a one-cycle select pulse for the matching extended register. The stored bits are decoded all the time into burst length, burst ordering, CAS latency, write recovery, test mode and power-down exit speed. A DLL-reset request comes out as a one-cycle pulse and is not held.

Every load-mode command starts a settling window that is `TMRD` clocks long. A small state machine with two states tracks it. In `MRD_IDLE` no window is open. A load moves it to `MRD_WAIT` (transition *load*). It stays in `MRD_WAIT` while the counter runs down, and any further load reloads the counter (transition *reload*). When the last count ends with no new load, it returns to `MRD_IDLE` (transition *expire*). A command that arrives inside the window is illegal. So is a load issued while a bank is open or a burst is running. Bad BA2/A13 bits and reserved field codes are also errors. Every one of these errors sets a sticky error flag, and a load still writes its bits even when it is illegal.

Top module: `ddr2_mrs_unit`

## Requirements
- R1: After reset, `busy`, `cmd_illegal`, `err_sticky`, `dll_rst` and `ext_sel` are all 0. The register holds all zeros, so `burst_len`, `cas_lat` and `wr_rec` read 0 (reserved).
- R2: A load with `bank_addr[1:0]`=00 stores `row_addr[12:0]`. One cycle later, `burst_len` reads 4 for M2..M0=010, 8 for 011, and 0 for any other code. Between loads to this register the stored bits do not change.
- R3: `burst_ilv` follows M3 (1 = interleaved), `test_mode` follows M7 (1 = test) and `pd_slow` follows M12 (1 = slow, low-power exit).
- R4: `cas_lat` reads 3..7 for M6..M4 = 011..111 and reads 0 for the reserved codes 000..010.
- R5: `wr_rec` reads 2..8 for M11..M9 = 001..111 and reads 0 for the reserved code 000.
- R6: A register load with M8=1 raises `dll_rst` for exactly the following cycle. The bit is never presented as held state.
- R7: A load with `bank_addr[1:0]` = 01, 10 or 11 raises `ext_sel` bit 0, 1 or 2 for one cycle and leaves the main register fields unchanged.
- R8: Every load-mode command holds `busy` high for `TMRD` (default 2) cycles after it. The cycles are counted again from the latest load.
- R9: Any command whose strobe falls in a cycle where `busy` is high raises `cmd_illegal` in the next cycle and sets `err_sticky`.
- R10: A load issued while `banks_idle`=0 or `burst_active`=1 raises `cmd_illegal` and `err_sticky`, and its bits are still stored.
- R11: A load with `bank_addr[2]`=1 or `row_addr[13]`=1, or a register load with a reserved burst-length, CAS-latency or write-recovery code, sets `err_sticky` without raising `cmd_illegal`. The bits are still stored.
- R12: Once set, `err_sticky` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_load | input | 1 | The present command is a load-mode command |
| bank_addr | input | 3 | Bank address; [1:0] selects the target register, [2] must be 0 |
| row_addr | input | 14 | Row address; [12:0] are the mode bits, [13] must be 0 |
| banks_idle | input | 1 | All banks precharged |
| burst_active | input | 1 | A read or write burst is in progress |
| busy | output | 1 | Settling window after a load is open |
| cmd_illegal | output | 1 | Previous-cycle command broke the timing or state rule |
| err_sticky | output | 1 | Any illegal or malformed load since reset |
| dll_rst | output | 1 | One-cycle DLL reset request |
| ext_sel | output | 3 | One-cycle select of extended register 1..3 |
| burst_len | output | 4 | 4, 8 or 0 for reserved |
| burst_ilv | output | 1 | Interleaved burst ordering |
| cas_lat | output | 3 | CAS latency 3..7 or 0 for reserved |
| wr_rec | output | 4 | Write recovery 2..8 or 0 for reserved |
| test_mode | output | 1 | Test operation selected |
| pd_slow | output | 1 | Slow power-down exit selected |

## Verification
Every result is due one clock after the edge that samples the command. The decoded fields, `dll_rst`, `ext_sel`, `cmd_illegal` and `err_sticky` all change at that same edge, and `busy` rises there and falls `TMRD` edges later. The bench drives inputs just after the falling edge. A behavioural model advances on the rising edge, and every output is compared against it at the next falling edge, so each result is sampled in its due cycle. Scenario checks at those same sample points cover reset and the error cases.

// File: rtl/ddr2_mrs_pkg.sv
package ddr2_mrs_pkg;
    localparam int MR_W        = 13;
    localparam int BL_LO       = 0;
    localparam int BT_BIT      = 3;
    localparam int CL_LO       = 4;
    localparam int TM_BIT      = 7;
    localparam int DLL_BIT     = 8;
    localparam int WR_LO       = 9;
    localparam int PD_BIT      = 12;
    localparam int N_EXT       = 3;

    typedef enum logic [0:0] {
        MRD_IDLE = 1'b0,
        MRD_WAIT = 1'b1
    } mrd_state_e;

    typedef struct packed {
        logic [3:0] bl;
        logic       ilv;
        logic [2:0] cl;
        logic [3:0] wr;
        logic       test;
        logic       pd_slow;
        logic       rsvd;
    } mr_view_t;
endpackage

// File: rtl/mrs_field_decode.sv
module mrs_field_decode
    import ddr2_mrs_pkg::*;
(
    input  logic [MR_W-1:0] bits,
    output mr_view_t        view
);
    logic [2:0] bl_code;
    logic [2:0] cl_code;
    logic [2:0] wr_code;
    logic       unused_dll;

    assign unused_dll = bits[DLL_BIT];

    always_comb begin
        bl_code = bits[BL_LO +: 3];
        cl_code = bits[CL_LO +: 3];
        wr_code = bits[WR_LO +: 3];
        view    = '0;
        unique case (bl_code)
            3'b010:  view.bl = 4'd4;
            3'b011:  view.bl = 4'd8;
            default: view.bl = 4'd0;
        endcase
        view.cl      = (cl_code >= 3'd3) ? cl_code : 3'd0;
        view.wr      = (wr_code != 3'd0) ? ({1'b0, wr_code} + 4'd1) : 4'd0;
        view.ilv     = bits[BT_BIT];
        view.test    = bits[TM_BIT];
        view.pd_slow = bits[PD_BIT];
        view.rsvd    = (view.bl == 4'd0) || (view.cl == 3'd0) || (view.wr == 4'd0);
    end
endmodule

// File: rtl/mrs_mrd_timer.sv
module mrs_mrd_timer
    import ddr2_mrs_pkg::*;
#(
    parameter int TMRD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(TMRD + 1);

    mrd_state_e     state;
    mrd_state_e     state_nxt;
    logic [CW-1:0]  cnt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            MRD_IDLE: if (start) state_nxt = MRD_WAIT;
            MRD_WAIT: if (!start && cnt == CW'(1)) state_nxt = MRD_IDLE;
            default:  state_nxt = MRD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MRD_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (start)        cnt <= CW'(TMRD);
        else if (cnt != '0)    cnt <= cnt - CW'(1);
    end

    always_comb begin
        busy = (state == MRD_WAIT);
    end

    a_r8_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    a_r8_busy_has_count: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt != '0));
    a_r8_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && cnt == CW'(1)) |=> !busy);
endmodule

// File: rtl/mrs_reg_store.sv
module mrs_reg_store
    import ddr2_mrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mr_wr,
    input  logic [MR_W-1:0]   wdata,
    input  logic [N_EXT-1:0]  ext_hit,
    input  logic              illegal_now,
    input  logic              fault_now,
    output logic [MR_W-1:0]   mr_bits,
    output logic              dll_rst,
    output logic [N_EXT-1:0]  ext_sel,
    output logic              cmd_illegal,
    output logic              err_sticky
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mr_bits     <= '0;
            dll_rst     <= 1'b0;
            ext_sel     <= '0;
            cmd_illegal <= 1'b0;
            err_sticky  <= 1'b0;
        end else begin
            if (mr_wr) mr_bits <= wdata;
            dll_rst     <= mr_wr && wdata[DLL_BIT];
            ext_sel     <= ext_hit;
            cmd_illegal <= illegal_now;
            if (illegal_now || fault_now) err_sticky <= 1'b1;
        end
    end

    a_r2_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_wr |=> $stable(mr_bits));
    a_r6_dll_from_load: assert property (@(posedge clk) disable iff (!rst_n)
        dll_rst |-> $past(mr_wr && wdata[DLL_BIT]));
    a_r7_ext_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ext_sel));
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);
endmodule

// File: rtl/ddr2_mrs_unit.sv
module ddr2_mrs_unit
    import ddr2_mrs_pkg::*;
#(
    parameter int TMRD = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_load,
    input  logic [2:0]  bank_addr,
    input  logic [13:0] row_addr,
    input  logic        banks_idle,
    input  logic        burst_active,
    output logic        busy,
    output logic        cmd_illegal,
    output logic        err_sticky,
    output logic        dll_rst,
    output logic [2:0]  ext_sel,
    output logic [3:0]  burst_len,
    output logic        burst_ilv,
    output logic [2:0]  cas_lat,
    output logic [3:0]  wr_rec,
    output logic        test_mode,
    output logic        pd_slow
);
    logic              lm;
    logic              mr_hit;
    logic [N_EXT-1:0]  ext_hit;
    logic              illegal_now;
    logic              fault_now;
    logic [MR_W-1:0]   mr_bits;
    mr_view_t          in_view;
    mr_view_t          st_view;
    logic              unused_views;

    assign lm     = cmd_valid && cmd_load;
    assign mr_hit = lm && (bank_addr[1:0] == 2'b00);

    generate
        for (genvar g = 0; g < N_EXT; g++) begin : g_ext
            assign ext_hit[g] = lm && (bank_addr[1:0] == 2'(g + 1));
        end
    endgenerate

    mrs_field_decode u_in_dec (.bits(row_addr[MR_W-1:0]), .view(in_view));
    mrs_field_decode u_st_dec (.bits(mr_bits),            .view(st_view));

    assign illegal_now = cmd_valid && (busy || (cmd_load && (!banks_idle || burst_active)));
    assign fault_now   = (lm && (bank_addr[2] || row_addr[13])) || (mr_hit && in_view.rsvd);
    assign unused_views = ^{in_view[$bits(mr_view_t)-1:1], st_view.rsvd};

    mrs_mrd_timer #(.TMRD(TMRD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (lm),
        .busy  (busy)
    );

    mrs_reg_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .mr_wr       (mr_hit),
        .wdata       (row_addr[MR_W-1:0]),
        .ext_hit     (ext_hit),
        .illegal_now (illegal_now),
        .fault_now   (fault_now),
        .mr_bits     (mr_bits),
        .dll_rst     (dll_rst),
        .ext_sel     (ext_sel),
        .cmd_illegal (cmd_illegal),
        .err_sticky  (err_sticky)
    );

    assign burst_len = st_view.bl;
    assign burst_ilv = st_view.ilv;
    assign cas_lat   = st_view.cl;
    assign wr_rec    = st_view.wr;
    assign test_mode = st_view.test;
    assign pd_slow   = st_view.pd_slow;

    a_r9_cmd_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> (cmd_illegal && err_sticky));
    a_r10_load_bad_state: assert property (@(posedge clk) disable iff (!rst_n)
        (lm && (!banks_idle || burst_active)) |=> (cmd_illegal && err_sticky));
    a_r7_ext_keeps_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (lm && bank_addr[1:0] != 2'b00) |=> ($stable(burst_len) && $stable(cas_lat) && $stable(wr_rec)));
endmodule

// File: tb/tb_ddr2_mrs_unit.sv
`timescale 1ns/1ps
module tb_ddr2_mrs_unit;
    localparam int TMRD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_load = 1'b0;
    logic [2:0]  bank_addr = '0;
    logic [13:0] row_addr = '0;
    logic        banks_idle = 1'b1, burst_active = 1'b0;
    logic        busy, cmd_illegal, err_sticky, dll_rst, burst_ilv, test_mode, pd_slow;
    logic [2:0]  ext_sel, cas_lat;
    logic [3:0]  burst_len, wr_rec;

    int checks = 0, fails = 0, cycles = 0;

    ddr2_mrs_unit #(.TMRD(TMRD)) dut (.*);

    always #5 clk = ~clk;

    // behavioural reference
    logic [12:0] m_bits = '0;
    int          m_cnt = 0;
    bit          m_dll = 0, m_ill = 0, m_err = 0;
    bit [2:0]    m_ext = '0;

    function automatic int exp_bl(input logic [12:0] b);
        if (b[2:0] == 3'd2) return 4;
        if (b[2:0] == 3'd3) return 8;
        return 0;
    endfunction
    function automatic int exp_cl(input logic [12:0] b);
        return (int'(b[6:4]) >= 3) ? int'(b[6:4]) : 0;
    endfunction
    function automatic int exp_wr(input logic [12:0] b);
        return (b[11:9] == 3'd0) ? 0 : int'(b[11:9]) + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bits = '0; m_cnt = 0; m_dll = 0; m_ill = 0; m_err = 0; m_ext = '0;
        end else begin
            bit was_busy;
            was_busy = (m_cnt > 0);
            m_dll = 0; m_ill = 0; m_ext = '0;
            if (cmd_valid && was_busy) m_ill = 1;
            if (cmd_valid && cmd_load) begin
                if (!banks_idle || burst_active) m_ill = 1;
                if (bank_addr[2] || row_addr[13]) m_err = 1;
                if (bank_addr[1:0] == 2'd0) begin
                    m_bits = row_addr[12:0];
                    m_dll  = row_addr[8];
                    if (exp_bl(m_bits) == 0 || exp_cl(m_bits) == 0 || exp_wr(m_bits) == 0) m_err = 1;
                end else begin
                    m_ext[bank_addr[1:0] - 1] = 1'b1;
                end
                m_cnt = TMRD;
            end else if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
            end
            if (m_ill) m_err = 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    bit cmp_en = 0;
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk("R2 burst_len",   burst_len,   exp_bl(m_bits));
            chk("R3 burst_ilv",   burst_ilv,   m_bits[3]);
            chk("R3 test_mode",   test_mode,   m_bits[7]);
            chk("R3 pd_slow",     pd_slow,     m_bits[12]);
            chk("R4 cas_lat",     cas_lat,     exp_cl(m_bits));
            chk("R5 wr_rec",      wr_rec,      exp_wr(m_bits));
            chk("R6 dll_rst",     dll_rst,     m_dll);
            chk("R7 ext_sel",     ext_sel,     m_ext);
            chk("R8 busy",        busy,        m_cnt > 0);
            chk("R9 cmd_illegal", cmd_illegal, m_ill);
            chk("R12 err_sticky", err_sticky,  m_err);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic drive(input bit v, input bit ld, input logic [2:0] ba, input logic [13:0] ra,
                         input bit idle, input bit bact);
        @(negedge clk); #1;
        cmd_valid = v; cmd_load = ld; bank_addr = ba; row_addr = ra;
        banks_idle = idle; burst_active = bact;
    endtask
    task automatic nop(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 3'd0, 14'd0, 1, 0);
    endtask
    task automatic load(input logic [2:0] ba, input logic [13:0] ra);
        drive(1, 1, ba, ra, 1, 0);
    endtask
    task automatic do_reset();
        @(negedge clk); #1; rst_n = 0;
        nop(2);
        @(negedge clk); #1; rst_n = 1;
    endtask
    function automatic logic [13:0] mk(input int bl, input int bt, input int cl, input int tm,
                                      input int dll, input int wr, input int pd);
        return 14'((bl & 7) | ((bt & 1) << 3) | ((cl & 7) << 4) | ((tm & 1) << 7) |
                   ((dll & 1) << 8) | ((wr & 7) << 9) | ((pd & 1) << 12));
    endfunction

    initial begin
        nop(3);
        @(negedge clk); #1; rst_n = 1;
        cmp_en = 1;
        @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset err", err_sticky, 0);
        chk("R1 reset burst_len", burst_len, 0);
        chk("R1 reset cas_lat", cas_lat, 0);

        // legal loads
        load(3'd0, mk(3, 0, 5, 0, 1, 3, 0)); nop(4);
        load(3'd0, mk(2, 1, 3, 1, 0, 7, 1)); nop(4);
        chk("R2 bl4 stored", burst_len, 4);
        chk("R5 wr8 stored", wr_rec, 8);
        load(3'd1, 14'h0fff); nop(3);
        load(3'd2, 14'h0123); nop(3);
        load(3'd3, 14'h0456); nop(3);
        chk("R7 fields kept", cas_lat, 3);
        chk("R11 legal loads no error", err_sticky, 0);

        // TMRD window: command right at the end of the window is legal when spaced
        load(3'd0, mk(3, 0, 4, 0, 0, 1, 0)); nop(TMRD);
        drive(1, 0, 3'd0, 14'd0, 1, 0); nop(3);
        chk("R8 spaced command legal", err_sticky, 0);

        // sweep every field code (reserved ones flag error)
        for (int c = 0; c < 8; c++) begin load(3'd0, mk(c, c & 1, 6, 0, 0, 2, 0)); nop(3); end
        for (int c = 0; c < 8; c++) begin load(3'd0, mk(3, 0, c, 0, 0, 2, 0)); nop(3); end
        for (int c = 0; c < 8; c++) begin load(3'd0, mk(2, 0, 7, 0, c & 1, c, 0)); nop(3); end
        chk("R11 reserved sets error", err_sticky, 1);
        nop(5);
        chk("R12 error remains", err_sticky, 1);

        // BA2 set
        do_reset();
        load(3'd4, mk(3, 0, 5, 0, 0, 3, 0)); nop(1);
        chk("R11 ba2 no illegal", cmd_illegal, 0);
        chk("R11 ba2 error", err_sticky, 1);
        nop(3);
        // A13 set
        do_reset();
        load(3'd0, 14'h2000 | mk(3, 0, 5, 0, 0, 3, 0)); nop(1);
        chk("R11 a13 error", err_sticky, 1);
        nop(3);
        // banks open
        do_reset();
        drive(1, 1, 3'd0, mk(2, 1, 6, 0, 1, 4, 1), 0, 0); nop(1);
        chk("R10 open bank illegal", cmd_illegal, 1);
        chk("R10 bits stored", cas_lat, 6);
        nop(3);
        // burst in progress
        do_reset();
        drive(1, 1, 3'd0, mk(3, 0, 7, 0, 0, 5, 0), 1, 1); nop(1);
        chk("R10 burst illegal", cmd_illegal, 1);
        nop(3);
        // command inside window, then back-to-back loads
        do_reset();
        load(3'd0, mk(3, 0, 5, 0, 0, 3, 0));
        drive(1, 0, 3'd0, 14'd0, 1, 0); nop(1);
        chk("R9 cmd in window", cmd_illegal, 1);
        nop(3);
        do_reset();
        load(3'd0, mk(3, 0, 5, 0, 1, 3, 0));
        load(3'd0, mk(2, 0, 5, 0, 1, 3, 0));
        nop(TMRD + 3);
        do_reset();
        load(3'd2, 14'd0); nop(1);
        drive(1, 1, 3'd3, 14'd0, 1, 0); nop(4);

        cmp_en = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule